// File: doc/BRIEF.md
# Word-Serial Modular Adder-Subtractor

This block forms either (A + B) mod N or (A - B) mod N for multi-word operands, one word per cycle. With the default parameters the operands are 256 bits wide, carried as eight 32-bit words. A start pulse selects the operation. The block then takes the words of A, B and the modulus N through a valid/ready input stream, least significant word first. Each accepted word passes through two chained arithmetic steps in the same cycle. In add mode these are the sum a + b and then that sum minus the modulus word. In subtract mode they are the difference a - b and then that difference plus the modulus word. Both candidate words are written into a pair of small buffers.

After the last input word, the final carry and borrow of the two chains decide which candidate is correct. The chosen buffer is then sent out word by word on a valid/ready output stream, least significant word first. A one-cycle done pulse follows the final output transfer. The caller must supply operands already reduced into the range [0, N).

On either stream a word moves only in a cycle where valid and ready are both high. The input side may hold its valid low for any number of cycles. The output side may hold its ready low for any number of cycles, and during such a stall the result word and its valid stay unchanged. The input and output phases never overlap.

Top module: `wsmod_addsub`

## Requirements
- R1: While reset is held and right after it, in_ready, out_valid and done are all low.
- R2: A start pulse while the block is idle latches op_sel (0 = add, 1 = subtract) and raises in_ready on the following cycle. A start pulse while an operation is in progress is ignored, and the operation in progress keeps its latched mode.
- R3: Input words are taken only in cycles with in_valid and in_ready both high, least significant word first. in_ready drops right after exactly NUM_WORDS words have been accepted.
- R4: In add mode, for A, B in [0, N), the result equals (A + B) mod N. This includes the boundary A + B = N - 1, which gives N - 1, and A + B = N, which gives 0.
- R5: In add mode, the uncorrected sum is kept only when the final borrow of the minus-N chain is 1 and the final carry of the sum chain is 0. When the final carry and the final borrow are both 1 they cancel, and the corrected value is kept. This covers a sum that overflows the operand width, for example when N is close to 2^(NUM_WORDS*WORD_W).
- R6: In subtract mode, for A, B in [0, N), the result equals (A - B) mod N. The value A - B + N is chosen exactly when the final borrow of the A - B chain is 1, and A = B gives 0.
- R7: The carry-in and borrow-in of the first word are both zero for every operation, whatever flags the previous operation left behind.
- R8: The result leaves as NUM_WORDS words, least significant first, each marked by out_valid. While out_valid is high and out_ready is low, out_data and out_valid hold their values.
- R9: done is a single-cycle pulse in the cycle after the last result word is transferred. in_ready and out_valid are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when the block is idle |
| op_sel | input | 1 | Operation taken with start: 0 add, 1 subtract |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts an input word |
| in_a | input | WORD_W | Word of operand A |
| in_b | input | WORD_W | Word of operand B |
| in_mod | input | WORD_W | Word of modulus N |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer accepts the result word |
| out_data | output | WORD_W | Result word |
| done | output | 1 | Pulse after the final result word |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that the two phases never overlap, that a stalled result word holds steady, that in_ready opens only after a start and closes only after an accepted word, and that done is a lone pulse following an output transfer. The arithmetic cannot be seen at that level. The bench shows it by sweeping every operand pair below a small modulus in a narrow configuration, with random bubbles and stalls. It also runs directed boundary cases at full width: sums just below and equal to N, equal operands, a negative difference, and a modulus near 2^256 that makes the carry and the borrow cancel. A start pulse injected during loading, and back-to-back operations whose earlier flags would corrupt a later one, are also exercised only by these scenarios.

// File: rtl/wsmas_pkg.sv
package wsmas_pkg;
  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} op_e;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_LOAD = 2'd1, PH_DRAIN = 2'd2} phase_e;
endpackage

// File: rtl/wsmas_lane.sv
// One word of both chains: first chain (sum or difference), then the
// modulus correction applied to that first-chain word.
module wsmas_lane
  import wsmas_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  input  logic         p_in,   // carry (add) or borrow (sub) of first chain
  input  logic         q_in,   // borrow (add) or carry (sub) of correction chain
  output logic [W-1:0] prim,
  output logic [W-1:0] corr,
  output logic         p_out,
  output logic         q_out
);
  localparam int XW = W + 1;

  logic [XW-1:0] first_x;
  logic [XW-1:0] second_x;

  always_comb begin
    if (op == OP_ADD) begin
      first_x  = {1'b0, a} + {1'b0, b} + XW'(p_in);
      second_x = {1'b0, first_x[W-1:0]} - {1'b0, m} - XW'(q_in);
    end else begin
      first_x  = {1'b0, a} - {1'b0, b} - XW'(p_in);
      second_x = {1'b0, first_x[W-1:0]} + {1'b0, m} + XW'(q_in);
    end
  end

  assign prim  = first_x[W-1:0];
  assign corr  = second_x[W-1:0];
  assign p_out = first_x[W];
  assign q_out = second_x[W];
endmodule

// File: rtl/wsmas_cand_buf.sv
// Two candidate buffers written together, read one at a time.
module wsmas_cand_buf #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wprim,
  input  logic [W-1:0]     wcorr,
  input  logic [IDX_W-1:0] ridx,
  input  logic             rsel_corr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] prim_w [DEPTH];
  logic [W-1:0] corr_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic [W-1:0] pr_q;
    logic [W-1:0] cr_q;
    always_ff @(posedge clk) begin
      if (we && widx == IDX_W'(g)) begin
        pr_q <= wprim;
        cr_q <= wcorr;
      end
    end
    assign prim_w[g] = pr_q;
    assign corr_w[g] = cr_q;
  end

  assign rdata = rsel_corr ? corr_w[ridx] : prim_w[ridx];
endmodule

// File: rtl/wsmas_ctrl.sv
// Phase sequencing and the shared word index.
module wsmas_ctrl
  import wsmas_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             start_ok,
  output logic             in_ready,
  output logic             in_fire,
  output logic             out_valid,
  output logic             out_fire,
  output logic             at_last,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  assign start_ok  = (phase_q == PH_IDLE) && start;
  assign in_ready  = (phase_q == PH_LOAD);
  assign out_valid = (phase_q == PH_DRAIN);
  assign in_fire   = in_ready && in_valid;
  assign out_fire  = out_valid && out_ready;
  assign at_last   = (idx_q == IDX_W'(DEPTH - 1));
  assign idx       = idx_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= out_fire && at_last;
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_LOAD;
            idx_q   <= '0;
          end
        end
        PH_LOAD: begin
          if (in_fire) begin
            if (at_last) begin
              phase_q <= PH_DRAIN;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        PH_DRAIN: begin
          if (out_fire) begin
            if (at_last) begin
              phase_q <= PH_IDLE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wsmod_addsub.sv
module wsmod_addsub
  import wsmas_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic [WORD_W-1:0] in_mod,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              done
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic             start_ok, in_fire, out_fire, at_last;
  logic [IDX_W-1:0] idx;

  op_e         op_q;
  logic        p_q, q_q;
  logic        take_corr_q;
  logic [WORD_W-1:0] lane_prim, lane_corr;
  logic        lane_p, lane_q;
  logic        final_corr;

  wsmas_ctrl #(.DEPTH(NUM_WORDS), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .start_ok (start_ok),
    .in_ready (in_ready),
    .in_fire  (in_fire),
    .out_valid(out_valid),
    .out_fire (out_fire),
    .at_last  (at_last),
    .idx      (idx),
    .done     (done)
  );

  wsmas_lane #(.W(WORD_W)) u_lane (
    .op   (op_q),
    .a    (in_a),
    .b    (in_b),
    .m    (in_mod),
    .p_in (p_q),
    .q_in (q_q),
    .prim (lane_prim),
    .corr (lane_corr),
    .p_out(lane_p),
    .q_out(lane_q)
  );

  // Add: plain sum survives only when the minus-N chain went negative and
  // the sum did not overflow. Sub: correction needed when a - b borrowed.
  always_comb begin
    if (op_q == OP_ADD) final_corr = !(lane_q && !lane_p);
    else                final_corr = lane_p;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q        <= OP_ADD;
      p_q         <= 1'b0;
      q_q         <= 1'b0;
      take_corr_q <= 1'b0;
    end else begin
      if (start_ok) begin
        op_q <= op_e'(op_sel);
        p_q  <= 1'b0;
        q_q  <= 1'b0;
      end else if (in_fire) begin
        p_q <= lane_p;
        q_q <= lane_q;
        if (at_last) take_corr_q <= final_corr;
      end
    end
  end

  wsmas_cand_buf #(.W(WORD_W), .DEPTH(NUM_WORDS), .IDX_W(IDX_W)) u_buf (
    .clk      (clk),
    .we       (in_fire),
    .widx     (idx),
    .wprim    (lane_prim),
    .wcorr    (lane_corr),
    .ridx     (idx),
    .rsel_corr(take_corr_q),
    .rdata    (out_data)
  );
endmodule

// File: rtl/wsmod_addsub_chk.sv
module wsmod_addsub_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              done
);
  assert_phase_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_open_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(start));

  assert_close_after_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));

  assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready));
endmodule

bind wsmod_addsub wsmod_addsub_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/wsmod_addsub_bench.sv
module wsmod_addsub_bench;
  localparam int SW = 3;
  localparam int SN = 2;
  localparam int SMOD = 53;
  localparam int WW = 32;
  localparam int WN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // small configuration
  logic s_start = 0, s_op = 0, s_in_valid = 0, s_in_ready, s_out_valid, s_out_ready = 0, s_done;
  logic [SW-1:0] s_a = 0, s_b = 0, s_m = 0, s_out;

  wsmod_addsub #(.WORD_W(SW), .NUM_WORDS(SN)) u_wsmod_addsub (
    .clk(clk), .rst_n(rst_n), .start(s_start), .op_sel(s_op),
    .in_valid(s_in_valid), .in_ready(s_in_ready), .in_a(s_a), .in_b(s_b), .in_mod(s_m),
    .out_valid(s_out_valid), .out_ready(s_out_ready), .out_data(s_out), .done(s_done));

  // full-width configuration
  logic w_start = 0, w_op = 0, w_in_valid = 0, w_in_ready, w_out_valid, w_out_ready = 0, w_done;
  logic [WW-1:0] w_a = 0, w_b = 0, w_m = 0, w_out;

  wsmod_addsub #(.WORD_W(WW), .NUM_WORDS(WN)) u_wsmod_addsub_wide (
    .clk(clk), .rst_n(rst_n), .start(w_start), .op_sel(w_op),
    .in_valid(w_in_valid), .in_ready(w_in_ready), .in_a(w_a), .in_b(w_b), .in_mod(w_m),
    .out_valid(w_out_valid), .out_ready(w_out_ready), .out_data(w_out), .done(w_done));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [256:0] act, input logic [256:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_small(input bit op, input int a, input int b);
    logic [SW*SN-1:0] res;
    int exp_v;
    bit prev_st;
    logic [SW-1:0] prev_w;
    int k;
    @(negedge clk); s_start = 1; s_op = op;
    @(negedge clk); s_start = 0; s_op = ~op;
    for (int i = 0; i < SN; ) begin
      if ($urandom % 4 == 0) begin
        s_in_valid = 0;
      end else begin
        s_in_valid = 1; s_a = SW'(a >> (i*SW)); s_b = SW'(b >> (i*SW)); s_m = SW'(SMOD >> (i*SW));
        i++;
      end
      @(negedge clk);
    end
    s_in_valid = 0;
    check(s_in_ready == 1'b0, "R3", "in_ready after last word", 257'(s_in_ready), 257'(0));
    k = 0; prev_st = 0; prev_w = '0;
    while (k < SN) begin
      bit r;
      r = ($urandom % 3 != 0);
      s_out_ready = r;
      if (prev_st) check(s_out_valid && s_out == prev_w, "R8", "stalled word held", 257'(s_out), 257'(prev_w));
      if (s_out_valid && r) begin
        res[k*SW +: SW] = s_out; k++; prev_st = 0;
      end else begin
        prev_st = s_out_valid; prev_w = s_out;
      end
      @(negedge clk);
    end
    s_out_ready = 0;
    check(s_done == 1'b1, "R9", "done after last word", 257'(s_done), 257'(1));
    if (op == 1'b0) exp_v = (a + b) % SMOD;
    else            exp_v = (a - b + SMOD) % SMOD;
    check(int'(res) == exp_v, op ? "R6" : "R4", "small result", 257'(res), 257'(exp_v));
  endtask

  task automatic run_wide(input bit op, input logic [255:0] a, input logic [255:0] b,
                          input logic [255:0] m, input bit poke_start, input bit stall,
                          input string req);
    logic [255:0] res;
    logic [256:0] exp_v;
    int k;
    @(negedge clk); w_start = 1; w_op = op;
    @(negedge clk); w_start = 0;
    for (int i = 0; i < WN; i++) begin
      w_in_valid = 1; w_a = a[i*WW +: WW]; w_b = b[i*WW +: WW]; w_m = m[i*WW +: WW];
      if (poke_start && i == 3) begin w_start = 1; w_op = ~op; end
      else w_start = 0;
      @(negedge clk);
    end
    w_in_valid = 0; w_start = 0;
    k = 0;
    while (k < WN) begin
      if (stall && k == 2) begin
        logic [WW-1:0] held;
        w_out_ready = 0; held = w_out;
        @(negedge clk); @(negedge clk);
        check(w_out_valid && w_out == held, "R8", "wide stall hold", 257'(w_out), 257'(held));
      end
      w_out_ready = 1;
      if (w_out_valid) begin res[k*WW +: WW] = w_out; k++; end
      @(negedge clk);
    end
    w_out_ready = 0;
    check(w_done == 1'b1, "R9", "wide done pulse", 257'(w_done), 257'(1));
    @(negedge clk);
    check(w_done == 1'b0, "R9", "done is one cycle", 257'(w_done), 257'(0));
    if (op == 1'b0) begin
      exp_v = {1'b0, a} + {1'b0, b};
      if (exp_v >= {1'b0, m}) exp_v = exp_v - {1'b0, m};
    end else begin
      exp_v = (a >= b) ? {1'b0, a - b} : ({1'b0, a} + {1'b0, m} - {1'b0, b});
    end
    check({1'b0, res} == exp_v, req, "wide result", {1'b0, res}, exp_v);
  endtask

  function automatic logic [255:0] rnd_below(input logic [255:0] m);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v % m;
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [255:0] n1, n2, x, y;
    n1 = (256'd1 << 255) - 256'd19;
    n2 = 256'd0 - 256'd38;
    repeat (3) @(negedge clk);
    check(!s_in_ready && !s_out_valid && !s_done, "R1", "small idle in reset", 257'({s_in_ready, s_out_valid, s_done}), 257'(0));
    rst_n = 1;
    @(negedge clk);
    check(!w_in_ready && !w_out_valid && !w_done, "R1", "wide idle after reset", 257'({w_in_ready, w_out_valid, w_done}), 257'(0));

    // R2: in_ready opens one cycle after start
    @(negedge clk); s_start = 1; s_op = 0;
    @(negedge clk); s_start = 0;
    check(s_in_ready == 1'b1, "R2", "in_ready after start", 257'(s_in_ready), 257'(1));
    for (int i = 0; i < SN; i++) begin s_in_valid = 1; s_a = 0; s_b = 0; s_m = SW'(SMOD >> (i*SW)); @(negedge clk); end
    s_in_valid = 0; s_out_ready = 1;
    repeat (SN + 1) @(negedge clk);
    s_out_ready = 0;

    // exhaustive small sweep: R4, R5 (sum overflow beyond 6 bits), R6, R7 (back to back)
    for (int a = 0; a < SMOD; a++)
      for (int b = 0; b < SMOD; b++) begin
        run_small(1'b0, a, b);
        run_small(1'b1, a, b);
      end

    // full-width boundary cases
    x = rnd_below(n1);
    run_wide(1'b0, n1 - 256'd1 - x, x, n1, 0, 0, "R4");   // a + b = N - 1
    run_wide(1'b0, n1 - x, x, n1, 0, 1, "R4");            // a + b = N
    run_wide(1'b1, x, x, n1, 0, 0, "R6");                 // a = b
    run_wide(1'b1, 256'd0, 256'd1, n1, 0, 0, "R6");       // negative difference
    run_wide(1'b0, n2 - 256'd1, n2 - 256'd1, n2, 0, 0, "R5"); // carry and borrow cancel
    run_wide(1'b0, 256'd5, 256'd7, n2, 0, 0, "R5");       // plain sum kept
    run_wide(1'b1, 256'd3, 256'd9, n1, 1, 0, "R2");       // start ignored mid-load
    run_wide(1'b0, 256'd0, 256'd0, n1, 0, 0, "R7");       // after a borrowing op
    for (int i = 0; i < 12; i++) begin
      x = rnd_below(n1); y = rnd_below(n1);
      run_wide(i[0], x, y, n1, 0, (i % 3) == 0, i[0] ? "R6" : "R4");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule